// File: doc/BRIEF.md
# Eight-Way One-Hot Output Selector

This block keeps a 3-bit index that names one of eight outputs and drives that output high while the others stay low. Software or control logic moves the selection in three ways: a level-sensitive load copies the low bits of a data word into the index, and rising edges on two step inputs move it one place up or down. The index wraps at both ends. An asynchronous reset returns the index to zero at any moment.

An enable input masks only the one-hot outputs. While it is low every output is low, yet loads, steps and resets still move the index, so the selection carries on in the background and shows up at once when the enable returns. The index itself is an output as well.

Each clock the arbiter picks one command: CMD_HOLD (no change), CMD_LOAD (index takes the load value), CMD_INC (index plus one, 7 wraps to 0) or CMD_DEC (index minus one, 0 wraps to 7). Reset ranks above all of them, load above both steps, and two step edges in the same cycle give CMD_HOLD. The step inputs are sampled on the clock, so an edge is a cycle where the input is high and was low at the clock before.

Top module: `sel8_onehot`

## Requirements
- R1: With `en_i` high, `sel_o` has exactly one bit set, the bit whose position equals `idx_o`.
- R2: With `en_i` low, `sel_o` is all zeros.
- R3: A low `en_i` does not stop load, steps or reset from changing `idx_o`.
- R4: With `load_i` high at a clock edge, `idx_o` takes bits [2:0] of `load_val_i`; the upper bits are ignored.
- R5: A high `rst` clears `idx_o` to 0 at once, without waiting for a clock edge.
- R6: A clock where `up_i` is high after being low at the previous clock raises `idx_o` by one; holding `up_i` high gives no further steps.
- R7: A clock where `dn_i` is high after being low at the previous clock lowers `idx_o` by one.
- R8: Stepping wraps: up from 7 gives 0, down from 0 gives 7.
- R9: A load in the same cycle as a step edge wins; the step is dropped.
- R10: Rising edges on `up_i` and `dn_i` in the same cycle leave `idx_o` unchanged.
- R11: While `rst` is high, a load has no effect and `idx_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high, index to 0 |
| en_i | input | 1 | Output enable for `sel_o` |
| load_i | input | 1 | Load the index from `load_val_i` |
| load_val_i | input | 8 | Load value, low 3 bits used |
| up_i | input | 1 | Step up on rising edge |
| dn_i | input | 1 | Step down on rising edge |
| sel_o | output | 8 | One-hot selected outputs |
| idx_o | output | 3 | Current index |

## Verification
Loads and step edges change `idx_o` at the first rising clock after they are presented, while `sel_o` follows `en_i` and `idx_o` with no register in between. The bench drives inputs on the falling edge, queues the expected index and outputs for that stimulus, and compares one time unit after the next rising edge, where both the registered index and the combinational outputs have settled. Reset is checked apart from the queue, a fraction of a cycle after it rises between clock edges, to show it acts without a clock.

// File: rtl/sel8_pkg.sv
package sel8_pkg;
    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_INC  = 2'd2,
        CMD_DEC  = 2'd3
    } step_cmd_e;
endpackage

// File: rtl/sel8_edge_det.sv
module sel8_edge_det #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic lvl_q;
        always_ff @(posedge clk or posedge rst) begin
            if (rst) lvl_q <= 1'b0;
            else     lvl_q <= lvl_i[b];
        end
        assign rise_o[b] = lvl_i[b] & ~lvl_q;
    end
endmodule

// File: rtl/sel8_step_arb.sv
module sel8_step_arb
    import sel8_pkg::*;
(
    input  logic      load_i,
    input  logic      inc_rise_i,
    input  logic      dec_rise_i,
    output step_cmd_e cmd_o
);
    always_comb begin
        if (load_i) begin
            cmd_o = CMD_LOAD;
        end else begin
            unique case ({inc_rise_i, dec_rise_i})
                2'b10:   cmd_o = CMD_INC;
                2'b01:   cmd_o = CMD_DEC;
                default: cmd_o = CMD_HOLD;
            endcase
        end
    end
endmodule

// File: rtl/sel8_state_reg.sv
module sel8_state_reg
    import sel8_pkg::*;
#(
    parameter int NUM_OUT = 8,
    parameter int IN_W    = 8,
    localparam int IDX_W  = $clog2(NUM_OUT)
) (
    input  logic             clk,
    input  logic             rst,
    input  step_cmd_e        cmd_i,
    input  logic [IN_W-1:0]  load_val_i,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(NUM_OUT - 1);

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_d;

    always_comb begin
        idx_d = idx_q;
        unique case (cmd_i)
            CMD_HOLD: idx_d = idx_q;
            CMD_LOAD: idx_d = load_val_i[IDX_W-1:0];
            CMD_INC:  idx_d = (idx_q == IDX_TOP) ? '0 : idx_q + 1'b1;
            CMD_DEC:  idx_d = (idx_q == '0) ? IDX_TOP : idx_q - 1'b1;
            default:  idx_d = idx_q;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) idx_q <= '0;
        else     idx_q <= idx_d;
    end

    assign idx_o = idx_q;
endmodule

// File: rtl/sel8_decode.sv
module sel8_decode #(
    parameter int NUM_OUT = 8,
    localparam int IDX_W  = $clog2(NUM_OUT)
) (
    input  logic               en_i,
    input  logic [IDX_W-1:0]   idx_i,
    output logic [NUM_OUT-1:0] sel_o
);
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        assign sel_o[k] = en_i && (idx_i == IDX_W'(k));
    end
endmodule

// File: rtl/sel8_onehot.sv
module sel8_onehot
    import sel8_pkg::*;
#(
    parameter int NUM_OUT = 8,
    parameter int IN_W    = 8,
    localparam int IDX_W  = $clog2(NUM_OUT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_i,
    input  logic               load_i,
    input  logic [IN_W-1:0]    load_val_i,
    input  logic               up_i,
    input  logic               dn_i,
    output logic [NUM_OUT-1:0] sel_o,
    output logic [IDX_W-1:0]   idx_o
);
    logic [1:0] rise;
    step_cmd_e  cmd;

    sel8_edge_det #(.W(2)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  ({up_i, dn_i}),
        .rise_o (rise)
    );

    sel8_step_arb u_arb (
        .load_i     (load_i),
        .inc_rise_i (rise[1]),
        .dec_rise_i (rise[0]),
        .cmd_o      (cmd)
    );

    sel8_state_reg #(.NUM_OUT(NUM_OUT), .IN_W(IN_W)) u_state (
        .clk        (clk),
        .rst        (rst),
        .cmd_i      (cmd),
        .load_val_i (load_val_i),
        .idx_o      (idx_o)
    );

    sel8_decode #(.NUM_OUT(NUM_OUT)) u_dec (
        .en_i  (en_i),
        .idx_i (idx_o),
        .sel_o (sel_o)
    );
endmodule

// File: rtl/sel8_onehot_chk.sv
module sel8_onehot_chk #(
    parameter int NUM_OUT = 8,
    parameter int IN_W    = 8,
    localparam int IDX_W  = $clog2(NUM_OUT)
) (
    input logic               clk,
    input logic               rst,
    input logic               en_i,
    input logic               load_i,
    input logic [IN_W-1:0]    load_val_i,
    input logic               up_i,
    input logic               dn_i,
    input logic [NUM_OUT-1:0] sel_o,
    input logic [IDX_W-1:0]   idx_o
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(NUM_OUT - 1);

    // R1
    one_hot_chk: assert property (@(posedge clk) disable iff (rst)
        en_i |-> ($countones(sel_o) == 1 && sel_o[idx_o]));

    // R2
    masked_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |-> (sel_o == '0));

    // R4
    load_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (idx_o == $past(load_val_i[IDX_W-1:0])));

    // R6
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(up_i) && !$rose(dn_i) && !load_i) |=>
        (idx_o == (($past(idx_o) == TOP) ? '0 : $past(idx_o) + 1'b1)));

    // R7
    step_dn_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(dn_i) && !$rose(up_i) && !load_i) |=>
        (idx_o == (($past(idx_o) == '0) ? TOP : $past(idx_o) - 1'b1)));

    // R10
    both_edges_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(up_i) && $rose(dn_i) && !load_i) |=> $stable(idx_o));

    // R5
    reset_zero_chk: assert property (@(posedge clk)
        rst |-> (idx_o == '0));
endmodule

bind sel8_onehot sel8_onehot_chk #(.NUM_OUT(NUM_OUT), .IN_W(IN_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en_i),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .up_i       (up_i),
    .dn_i       (dn_i),
    .sel_o      (sel_o),
    .idx_o      (idx_o)
);

// File: tb/sim_sel8_onehot.sv
`timescale 1ns/1ps
module sim_sel8_onehot;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_i = 1'b1;
    logic       load_i = 1'b0;
    logic [7:0] load_val_i = '0;
    logic       up_i = 1'b0;
    logic       dn_i = 1'b0;
    logic [7:0] sel_o;
    logic [2:0] idx_o;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [2:0] idx;
        logic [7:0] sel;
        string      tag;
    } exp_t;
    exp_t sb[$];

    logic [2:0] m_idx = '0;
    logic       m_up = 1'b0;
    logic       m_dn = 1'b0;

    always #2 clk = ~clk;

    sel8_onehot u0 (
        .clk(clk), .rst(rst), .en_i(en_i), .load_i(load_i),
        .load_val_i(load_val_i), .up_i(up_i), .dn_i(dn_i),
        .sel_o(sel_o), .idx_o(idx_o)
    );

    function automatic logic [7:0] exp_sel(input logic en, input logic [2:0] idx);
        return en ? (8'd1 << idx) : 8'd0;
    endfunction

    task automatic check(input string tag, input logic [2:0] e_idx, input logic [7:0] e_sel);
        checks++;
        if (idx_o !== e_idx || sel_o !== e_sel) begin
            fails++;
            $display("FAIL %s: idx=%0d sel=%08b expected idx=%0d sel=%08b",
                     tag, idx_o, sel_o, e_idx, e_sel);
        end
    endtask

    // driver: apply one cycle of stimulus and queue its expected result
    task automatic drive(input string tag, input logic en, input logic ld,
                         input logic [7:0] val, input logic up, input logic dn);
        logic ru;
        logic rd;
        exp_t e;
        @(negedge clk);
        en_i = en; load_i = ld; load_val_i = val; up_i = up; dn_i = dn;
        ru = up && !m_up;
        rd = dn && !m_dn;
        if (ld)             m_idx = val[2:0];
        else if (ru && !rd) m_idx = m_idx + 3'd1;
        else if (rd && !ru) m_idx = m_idx - 3'd1;
        m_up = up;
        m_dn = dn;
        e.idx = m_idx;
        e.sel = exp_sel(en, m_idx);
        e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, e.idx, e.sel);
            end
        end
    end

    initial begin
        #800000;
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #0.5;
        check("R5 reset at start", 3'd0, 8'h01);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        drive("R4 R1 load 5", 1, 1, 8'd5, 0, 0);
        drive("R4 upper bits ignored", 1, 1, 8'hFB, 0, 0);
        drive("R6 hold after load", 1, 0, 8'h00, 0, 0);
        drive("R6 up edge", 1, 0, 8'h00, 1, 0);
        drive("R6 up held no step", 1, 0, 8'h00, 1, 0);
        drive("R6 up released", 1, 0, 8'h00, 0, 0);
        drive("R6 second up edge", 1, 0, 8'h00, 1, 0);
        drive("R7 dn edge", 1, 0, 8'h00, 0, 1);
        drive("R7 dn held", 1, 0, 8'h00, 0, 1);
        drive("R7 release", 1, 0, 8'h00, 0, 0);
        drive("R8 load 7", 1, 1, 8'd7, 0, 0);
        drive("R8 wrap up 7 to 0", 1, 0, 8'h00, 1, 0);
        drive("R8 release", 1, 0, 8'h00, 0, 0);
        drive("R8 wrap down 0 to 7", 1, 0, 8'h00, 0, 1);
        drive("R8 release", 1, 0, 8'h00, 0, 0);
        drive("R2 enable low masks", 0, 0, 8'h00, 0, 0);
        drive("R3 up edge while masked", 0, 0, 8'h00, 1, 0);
        drive("R3 release while masked", 0, 0, 8'h00, 0, 0);
        drive("R3 load while masked", 0, 1, 8'd2, 0, 0);
        drive("R3 dn edge while masked", 0, 0, 8'h00, 0, 1);
        drive("R1 enable restored", 1, 0, 8'h00, 0, 0);
        drive("R10 both edges hold", 1, 0, 8'h00, 1, 1);
        drive("R10 release", 1, 0, 8'h00, 0, 0);
        drive("R9 load beats up edge", 1, 1, 8'd6, 1, 0);
        drive("R9 release", 1, 0, 8'h00, 0, 0);
        drive("R9 load beats dn edge", 1, 1, 8'd3, 0, 1);
        drive("R9 release", 1, 0, 8'h00, 0, 0);

        // asynchronous reset between edges, with a load held (R5, R11)
        @(negedge clk);
        #0.5;
        rst = 1'b1;
        load_i = 1'b1;
        load_val_i = 8'd6;
        #0.5;
        check("R5 async reset no clock", 3'd0, 8'h01);
        @(posedge clk);
        #1;
        check("R11 load ignored in reset", 3'd0, 8'h01);
        @(negedge clk);
        rst = 1'b0;
        load_i = 1'b0;
        m_idx = '0;
        m_up = 1'b0;
        m_dn = 1'b0;
        drive("R6 step after reset", 1, 0, 8'h00, 1, 0);
        drive("R6 release", 1, 0, 8'h00, 0, 0);

        @(negedge clk);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule